// File: doc/BRIEF.md
# Autobaud Serial Debug Link

This block is a half-duplex asynchronous serial receiver and transmitter that learns its bit rate from the line. It does not use a configured divisor. After reset it is uncalibrated and does nothing until the host sends a calibration character, 0x80. That character produces one low stretch exactly eight bit times long: the start bit plus seven zero data bits. The block counts system clock cycles across that stretch and divides the count by eight to get the bit period in clocks. It then uses that period for every later receive sample and transmit bit.

Frames are 1 start bit (low), 8 data bits with the least significant bit first, and 1 stop bit (high). The idle line is high.

Received bytes leave on a valid/data port that has no back-pressure. A byte is offered for exactly one cycle, and the consumer must take it then. Bytes to send enter on a valid/ready port. A byte transfers on a cycle where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the producer holds `tx_data` steady. The status pins `locked`, `cal_err` and `frame_err` are plain levels or pulses.

Top module: `autobaud_link`

## Requirements
- R1: The serial frame is one low start bit, eight data bits sent and received least significant bit first, and one high stop bit. The idle line is high.
- R2: While reset is held and right after it, `locked`, `cal_err`, `rx_valid`, `frame_err` and `tx_ready` are 0 and `ser_out` is 1.
- R3: L is the number of consecutive rising clock edges at which `ser_in` is sampled low in the first low stretch. If 32 <= L <= 4096, `locked` rises two clock edges after the first edge at which `ser_in` is sampled high again. The bit period becomes floor(L/8) clocks.
- R4: If the low stretch ends with L < 32, `cal_err` pulses for one cycle and `locked` stays 0. The block then waits for a new low stretch.
- R5: If the line is still low at the 4097th sampled low edge, `cal_err` pulses for one cycle while the line is low. The block then ignores the line until it goes high, and returns to waiting uncalibrated.
- R6: The calibration character is never delivered. No `rx_valid` or `frame_err` occurs while `locked` is 0.
- R7: Once set, `locked` stays 1 and the bit period stays fixed until reset, whatever arrives later, including another 0x80.
- R8: When locked, a start edge is confirmed half a bit period later. The data bits and the stop bit are then sampled at whole bit periods. A high stop bit gives a one-cycle `rx_valid` with the byte on `rx_data`, and `rx_data` holds between pulses.
- R9: A stop bit sampled low gives a one-cycle `frame_err` instead of `rx_valid`, and `locked` stays 1.
- R10: A low pulse that has ended by the half-bit confirmation produces neither `rx_valid` nor `frame_err`, and the next frame is received normally.
- R11: `tx_ready` is 1 only when the block is locked and not sending. After a handshake, `ser_out` sends the frame starting on the next cycle with each bit lasting one bit period, `tx_ready` is 0 for the whole frame, and `tx_ready` returns one cycle after the stop bit ends.
- R12: `tx_valid` has no effect while unlocked: `ser_out` stays 1 and `tx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial receive line, asynchronous |
| ser_out | output | 1 | Serial transmit line, idle high |
| rx_valid | output | 1 | One-cycle pulse when a received byte is on rx_data |
| rx_data | output | 8 | Last received byte |
| tx_valid | input | 1 | Byte offered for sending |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_data | input | 8 | Byte to send, held while tx_valid waits |
| locked | output | 1 | Bit rate learned |
| cal_err | output | 1 | One-cycle pulse on a rejected calibration |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench builds the block with its default parameters: a 512-clock longest bit period, a 32-clock shortest calibration stretch and 8 data bits. These defaults put both calibration limits within a few thousand cycles. The bench calibrates at the fastest legal period (L=32, four clocks per bit), at the slowest (L=4096, 512 clocks per bit), and at an L that is not a multiple of eight (107, giving a 13-clock period). It also forces a 31-cycle and a 4200-cycle low stretch to reach both rejection paths.

// File: rtl/abl_pkg.sv
`timescale 1ns/1ps
package abl_pkg;
  typedef enum logic [1:0] {CAL_IDLE, CAL_MEASURE, CAL_ABORT, CAL_DONE} cal_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/abl_sync.sv
`timescale 1ns/1ps
// Flop chain that brings the asynchronous line into the clock domain.
module abl_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= IDLE_VAL;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{IDLE_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/abl_calib.sv
`timescale 1ns/1ps
// Measures the low stretch of the calibration character and derives the bit period.
module abl_calib import abl_pkg::*; #(
  parameter int DIV_W     = 10,
  parameter int LOW_SHIFT = 3,
  parameter int MAX_LOW   = 4096,
  parameter int MIN_LOW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  output logic             locked,
  output logic             cal_err,
  output logic [DIV_W-1:0] divisor
);
  localparam int CNT_W = DIV_W + LOW_SHIFT;

  cal_state_t       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CAL_IDLE;
      cnt     <= '0;
      cal_err <= 1'b0;
      divisor <= '0;
    end else begin
      cal_err <= 1'b0;
      case (st)
        CAL_IDLE: begin
          if (!line) begin
            cnt <= CNT_W'(1);
            st  <= CAL_MEASURE;
          end
        end
        CAL_MEASURE: begin
          if (!line) begin
            if (cnt == CNT_W'(MAX_LOW)) begin
              cal_err <= 1'b1;
              st      <= CAL_ABORT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt < CNT_W'(MIN_LOW)) begin
            cal_err <= 1'b1;
            st      <= CAL_IDLE;
          end else begin
            divisor <= cnt[CNT_W-1 -: DIV_W];
            st      <= CAL_DONE;
          end
        end
        CAL_ABORT: begin
          if (line) st <= CAL_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign locked = (st == CAL_DONE);
endmodule

// File: rtl/abl_rx.sv
`timescale 1ns/1ps
// Receiver: start-edge search, half-bit confirmation, whole-bit sampling.
module abl_rx import abl_pkg::*; #(
  parameter int DIV_W     = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 line,
  input  logic [DIV_W-1:0]     divisor,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 frame_err
);
  localparam int IDX_W = $clog2(DATA_BITS);

  rx_state_t            st;
  logic [DIV_W-1:0]     tmr;
  logic [IDX_W-1:0]     idx;
  logic                 line_q;
  logic [DATA_BITS-1:0] shreg;
  logic [DIV_W-1:0]     half_m1;
  logic [DIV_W-1:0]     full_m1;
  logic                 tick;

  assign half_m1 = (divisor >> 1) - 1'b1;
  assign full_m1 = divisor - 1'b1;
  assign tick    = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tmr       <= '0;
      idx       <= '0;
      line_q    <= 1'b1;
      shreg     <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      frame_err <= 1'b0;
    end else begin
      line_q    <= line;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (en && line_q && !line) begin
            tmr <= half_m1;
            st  <= RX_START;
          end
        end
        RX_START: begin
          if (tick) begin
            if (!line) begin
              tmr <= full_m1;
              idx <= '0;
              st  <= RX_DATA;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        RX_DATA: begin
          if (tick) begin
            shreg <= {line, shreg[DATA_BITS-1:1]};
            tmr   <= full_m1;
            idx   <= idx + 1'b1;
            if (idx == IDX_W'(DATA_BITS-1)) st <= RX_STOP;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (line) begin
              rx_valid <= 1'b1;
              rx_data  <= shreg;
            end else begin
              frame_err <= 1'b1;
            end
            st <= RX_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abl_tx.sv
`timescale 1ns/1ps
// Transmitter: one frame per handshake, each bit held for one learned period.
module abl_tx #(
  parameter int DIV_W     = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [DIV_W-1:0]     divisor,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  output logic                 ser_out
);
  localparam int FRAME_W = DATA_BITS + 2;
  localparam int NB_W    = $clog2(FRAME_W);

  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   tmr;
  logic [NB_W-1:0]    nbit;

  assign tx_ready = en && !busy;
  assign ser_out  = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      tmr   <= '0;
      nbit  <= '0;
    end else if (!busy) begin
      if (tx_valid && tx_ready) begin
        busy  <= 1'b1;
        shreg <= {1'b1, tx_data, 1'b0};
        tmr   <= divisor - 1'b1;
        nbit  <= '0;
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else if (nbit == NB_W'(FRAME_W-1)) begin
      busy <= 1'b0;
    end else begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      nbit  <= nbit + 1'b1;
      tmr   <= divisor - 1'b1;
    end
  end
endmodule

// File: rtl/autobaud_link.sv
`timescale 1ns/1ps
module autobaud_link #(
  parameter int MAX_BIT_CLKS = 512,
  parameter int MIN_LOW_CLKS = 32,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  output logic                 ser_out,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 locked,
  output logic                 cal_err,
  output logic                 frame_err
);
  localparam int DIV_W     = $clog2(MAX_BIT_CLKS + 1);
  localparam int LOW_SHIFT = $clog2(DATA_BITS);
  localparam int MAX_LOW   = MAX_BIT_CLKS * DATA_BITS;

  logic             line_s;
  logic [DIV_W-1:0] divisor;

  abl_sync #(.STAGES(2), .IDLE_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .dout(line_s)
  );

  abl_calib #(
    .DIV_W(DIV_W), .LOW_SHIFT(LOW_SHIFT), .MAX_LOW(MAX_LOW), .MIN_LOW(MIN_LOW_CLKS)
  ) i_calib (
    .clk(clk), .rst_n(rst_n), .line(line_s),
    .locked(locked), .cal_err(cal_err), .divisor(divisor)
  );

  abl_rx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) i_rx (
    .clk(clk), .rst_n(rst_n), .en(locked), .line(line_s), .divisor(divisor),
    .rx_valid(rx_valid), .rx_data(rx_data), .frame_err(frame_err)
  );

  abl_tx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) i_tx (
    .clk(clk), .rst_n(rst_n), .en(locked), .divisor(divisor),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .ser_out(ser_out)
  );
endmodule

// File: rtl/abl_checker.sv
`timescale 1ns/1ps
module abl_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 locked,
  input logic                 cal_err,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic                 ser_out,
  input logic                 rx_valid,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 frame_err
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked); // R7
  AST_CAL_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cal_err |=> !cal_err); // R4
  AST_CAL_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) cal_err |-> !locked); // R5
  AST_READY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> locked); // R11
  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) !locked |-> ser_out); // R12
  AST_RX_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid || frame_err) |-> locked); // R6
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R8
  AST_RX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |-> $stable(rx_data)); // R8
  AST_RX_OR_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !(rx_valid && frame_err)); // R9
  AST_TX_START_BIT: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> (!ser_out && !tx_ready)); // R1
endmodule

bind autobaud_link abl_checker #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .cal_err(cal_err),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .ser_out(ser_out),
  .rx_valid(rx_valid), .rx_data(rx_data), .frame_err(frame_err)
);

// File: tb/test_autobaud_link.sv
`timescale 1ns/1ps
module test_autobaud_link;
  localparam int MAX_BIT = 512;
  localparam int MIN_LOW = 32;
  localparam int DW      = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_in = 1'b1;
  logic          tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          ser_out, rx_valid, tx_ready, locked, cal_err, frame_err;
  logic [DW-1:0] rx_data;

  always #4 clk = ~clk;

  autobaud_link #(.MAX_BIT_CLKS(MAX_BIT), .MIN_LOW_CLKS(MIN_LOW), .DATA_BITS(DW)) i_autobaud_link (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .locked(locked), .cal_err(cal_err), .frame_err(frame_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int rxq[$];
  bit outq[$];
  int m_state = 0, m_run = 0, m_div = 0;
  bit m_locked = 0, m_err = 0;
  bit h0 = 1, h1 = 1, h2 = 1, rst_prev = 0, acc_pend = 0;
  logic [DW-1:0] acc_data = '0;
  int err_seen = 0, rx_events = 0;
  bit quiet_ok = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference, advanced once per clock and compared at the falling edge
  always @(negedge clk) begin
    bit v, exp_rdy, exp_out;
    int got;
    v = h2; h2 = h1; h1 = h0; h0 = ser_in;
    if (!rst_n) begin
      m_state = 0; m_run = 0; m_div = 0; m_locked = 0; m_err = 0;
      acc_pend = 0; outq.delete();
    end else if (rst_prev) begin
      m_err = 0;
      case (m_state)
        0: if (!v) begin m_run = 1; m_state = 1; end
        1: if (!v) begin
             if (m_run == MAX_BIT * DW) begin m_err = 1; m_state = 2; end
             else m_run++;
           end else if (m_run < MIN_LOW) begin m_err = 1; m_state = 0; end
           else begin m_locked = 1; m_div = m_run / DW; m_state = 3; end
        2: if (v) m_state = 0;
        default: ;
      endcase
      if (acc_pend)
        for (int i = 0; i < 10 * m_div; i++) begin
          int k;
          k = i / m_div;
          outq.push_back(k == 0 ? 1'b0 : (k == 9 ? 1'b1 : acc_data[k-1]));
        end
    end
    rst_prev = rst_n;
    exp_rdy = m_locked && (outq.size() == 0);
    exp_out = (outq.size() != 0) ? outq.pop_front() : 1'b1;
    check(locked === m_locked, "R3 locked", locked, m_locked);
    check(cal_err === m_err, "R4/R5 cal_err", cal_err, m_err);
    check(tx_ready === exp_rdy, "R11 tx_ready", tx_ready, exp_rdy);
    check(ser_out === exp_out, "R11 ser_out", ser_out, exp_out);
    if (!m_locked && (ser_out !== 1'b1 || tx_ready !== 1'b0)) quiet_ok = 0;
    acc_pend = tx_valid && exp_rdy;
    acc_data = tx_data;
    if (cal_err) err_seen++;
    if (rx_valid) begin
      rx_events++;
      if (rxq.size() == 0) check(0, "R6 unexpected rx_valid", rx_data, -1);
      else begin
        got = rxq.pop_front();
        check(int'(rx_data) == got, "R8 rx_data", rx_data, got);
      end
    end
    if (frame_err) begin
      rx_events++;
      if (rxq.size() == 0) check(0, "R9 unexpected frame_err", 1, 0);
      else begin
        got = rxq.pop_front();
        check(got == -1, "R9 frame_err in place of byte", -1, got);
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drive_low(input int len);
    @(posedge clk); #2 ser_in = 1'b0;
    repeat (len) @(posedge clk);
    #2 ser_in = 1'b1;
  endtask

  task automatic send_rx(input int per, input logic [DW-1:0] b, input bit good);
    logic [9:0] fr;
    fr = {good, b, 1'b0};
    rxq.push_back(good ? int'(b) : -1);
    @(posedge clk); #2;
    for (int i = 0; i < 10; i++) begin
      ser_in = fr[i];
      repeat (per) @(posedge clk);
      #2;
    end
    ser_in = 1'b1;
    hold(2 * per);
    check(rxq.size() == 0, "R8 frame outcome reported", rxq.size(), 0);
  endtask

  task automatic send_tx(input logic [DW-1:0] b);
    @(posedge clk); #2;
    tx_valid = 1'b1; tx_data = b;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #2 tx_valid = 1'b0;
    do @(negedge clk); while (!tx_ready);
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 1'b0;
    hold(3);
    rst_n = 1'b1;
  endtask

  initial begin
    int ev;
    repeat (3) @(negedge clk);
    check(locked === 1'b0 && cal_err === 1'b0, "R2 reset status", {locked, cal_err}, 0);
    check(rx_valid === 1'b0 && frame_err === 1'b0, "R2 reset rx", {rx_valid, frame_err}, 0);
    check(tx_ready === 1'b0 && ser_out === 1'b1, "R2 reset tx", {tx_ready, ser_out}, 1);
    @(posedge clk); #2 rst_n = 1'b1;

    // R12: offered byte while uncalibrated
    hold(2); tx_valid = 1'b1; tx_data = 8'h5A;
    hold(20); tx_valid = 1'b0;
    hold(2);
    check(quiet_ok, "R12 tx ignored while unlocked", quiet_ok, 1);

    // R4: one cycle too short
    drive_low(31); hold(10);
    check(err_seen == 1 && locked === 1'b0, "R4 short stretch rejected", err_seen, 1);
    // R5: too long
    drive_low(4200); hold(10);
    check(err_seen == 2 && locked === 1'b0, "R5 long stretch rejected", err_seen, 2);

    // R3: shortest legal stretch, 4 clocks per bit
    drive_low(32); hold(12);
    check(locked === 1'b1, "R3 lock at L=32", locked, 1);
    check(rx_events == 0, "R6 calibration byte not delivered", rx_events, 0);

    send_rx(4, 8'hA5, 1);
    send_rx(4, 8'h00, 1);
    send_rx(4, 8'hFF, 1);
    send_rx(4, 8'h01, 1);   // R1: lone set bit must land in bit 0
    send_rx(4, 8'h80, 1);
    check(locked === 1'b1, "R7 lock kept after later 0x80", locked, 1);
    send_rx(4, 8'hC6, 0);
    check(locked === 1'b1, "R9 lock kept after frame error", locked, 1);

    // R10: low glitch shorter than half a bit
    ev = rx_events;
    @(posedge clk); #2 ser_in = 1'b0;
    @(posedge clk); #2 ser_in = 1'b1;
    hold(40);
    check(rx_events == ev, "R10 glitch ignored", rx_events, ev);
    send_rx(4, 8'h3C, 1);

    send_tx(8'h5A);
    send_tx(8'hC3);
    hold(4);
    check(outq.size() == 0 && tx_ready === 1'b1, "R11 tx back to ready", tx_ready, 1);

    // R3: slowest legal rate
    do_reset();
    drive_low(4096); hold(1100);
    check(locked === 1'b1, "R3 lock at L=4096", locked, 1);
    send_rx(512, 8'h96, 1);
    send_tx(8'h81);

    // R3: stretch not a multiple of eight, period truncates to 13
    do_reset();
    drive_low(107); hold(30);
    check(locked === 1'b1, "R3 lock at L=107", locked, 1);
    send_rx(13, 8'h4B, 1);
    send_tx(8'hE7);
    hold(10);
    check(rxq.size() == 0, "R8 all expected bytes seen", rxq.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule